// File: doc/BRIEF.md
# Two-Level Cascaded DMA Request Arbiter

This block decides which DMA channel gets the bus when two four-channel DMA controllers are chained. The upstream controller ("master") owns the hold handshake with the CPU. The downstream controller ("slave") folds all of its pending work into a single cascade request. That cascade request occupies the master's channel 0. Each channel presents a request flag and a mask bit. The arbiter registers which channels are eligible, raises the cascade request and the CPU hold-request, and waits for hold-acknowledge. It then names one winning channel and drives that channel's acknowledge.

Priority is fixed and the lowest channel number wins. The master is resolved first. When master channel 0 (the cascade) wins, the master's cascade acknowledge is raised and the slave's own channels are searched for the winner. A grant stays fixed until the data mover reports terminal count or the CPU withdraws hold-acknowledge. At that point every handshake output is released together.

Top module: `cascade_dma_arbiter`

## Requirements
- R1: While reset is active, and on the first clock after it, every output is 0.
- R2: A channel is eligible only when its request flag is 1 and its mask bit is 0. A masked request never raises hold-request or cascade request, and never wins a grant. Masking master channel 0 blocks the whole slave.
- R3: `casc_req` becomes 1 one clock after any slave channel is eligible, and 0 one clock after none is. This holds only while no grant is active.
- R4: `hrq` becomes 1 one clock after any master channel is eligible, and 0 one clock after none is. Master channels 1..3 are taken from `mst_req`. Master channel 0 is eligible when `casc_req` is 1 and `mst_mask[0]` is 0. This holds only while no grant is active.
- R5: At a clock edge with no grant active, `hlda`=1 and `hrq`=1, the lowest-numbered eligible master channel wins. If that channel is not 0, the next cycle shows `grant_valid`=1, `grant_slave`=0, `grant_ch` = the channel, and `mst_dack` one-hot at that channel's bit (bit n = channel n).
- R6: If master channel 0 wins, the lowest-numbered eligible slave channel is granted. The next cycle shows `grant_slave`=1, `grant_ch` = the slave channel, `slv_dack` one-hot at that bit, and `mst_dack` = 0001 (the cascade acknowledge).
- R7: If master channel 0 wins but no slave channel is eligible at that edge, no grant is made. The arbiter keeps waiting and grants once a channel becomes eligible.
- R8: While a grant is active, and `tc` stays 0 and `hlda` stays 1, the grant outputs, `hrq` and `casc_req` stay unchanged, whatever the requests and masks do.
- R9: A clock edge with a grant active and `tc`=1 releases everything. On the next cycle `hrq`, `casc_req`, `grant_valid`, `mst_dack` and `slv_dack` are all 0. Eligibility is sampled again at the edge after that.
- R10: A clock edge with a grant active and `hlda`=0 releases everything in the same way as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_req | input | NCH-1 | Request flags of master channels 1..NCH-1 |
| mst_mask | input | NCH | Mask bits of master channels 0..NCH-1 |
| slv_req | input | NCH | Request flags of slave channels |
| slv_mask | input | NCH | Mask bits of slave channels |
| hlda | input | 1 | Hold-acknowledge from the CPU |
| tc | input | 1 | Terminal count of the granted transfer |
| hrq | output | 1 | Hold-request to the CPU |
| casc_req | output | 1 | Slave's combined request into master channel 0 |
| grant_valid | output | 1 | A channel is currently granted |
| grant_slave | output | 1 | Granted channel belongs to the slave |
| grant_ch | output | $clog2(NCH) | Granted channel number |
| mst_dack | output | NCH | Master per-channel acknowledge (bit 0 = cascade ack) |
| slv_dack | output | NCH | Slave per-channel acknowledge |

## Verification
The hardest state to reach is R7. There, master channel 0 wins on a registered cascade request that has already gone stale, because the slave's requests were masked in the same cycle that hold-acknowledge rose. The bench reaches it by building a slave-only request until `hrq` is high, then masking every slave channel and raising `hlda` on one edge. It then checks that no grant appears, that the request lines collapse over the next two clocks, and that a later unmask produces a slave grant. Per-cycle comparison against a behavioural model also covers grants that are held while requests and masks change under them.

// File: rtl/cascade_dma_arbiter.sv
module cascade_dma_arbiter #(
  parameter int NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:1]         mst_req,
  input  logic [NCH-1:0]         mst_mask,
  input  logic [NCH-1:0]         slv_req,
  input  logic [NCH-1:0]         slv_mask,
  input  logic                   hlda,
  input  logic                   tc,
  output logic                   hrq,
  output logic                   casc_req,
  output logic                   grant_valid,
  output logic                   grant_slave,
  output logic [$clog2(NCH)-1:0] grant_ch,
  output logic [NCH-1:0]         mst_dack,
  output logic [NCH-1:0]         slv_dack
);
  localparam int CW = $clog2(NCH);

  function automatic logic [CW-1:0] lowest(input logic [NCH-1:0] v);
    logic [CW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (v[i]) r = CW'(i);
    return r;
  endfunction

  logic          hrq_q, casc_q, act_q, slv_q;
  logic [CW-1:0] ch_q;

  logic [NCH-1:0] slv_elig, mst_elig;
  logic [CW-1:0]  mst_pick, slv_pick;
  logic           start, release_now;

  assign slv_elig = slv_req & ~slv_mask;
  assign mst_elig = {mst_req, casc_q} & ~mst_mask;
  assign mst_pick = lowest(mst_elig);
  assign slv_pick = lowest(slv_elig);

  assign start       = !act_q && hlda && hrq_q && (|mst_elig) &&
                       ((mst_pick != '0) || (|slv_elig));
  assign release_now = act_q && (tc || !hlda);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hrq_q  <= 1'b0;
      casc_q <= 1'b0;
      act_q  <= 1'b0;
      slv_q  <= 1'b0;
      ch_q   <= '0;
    end else if (release_now) begin
      hrq_q  <= 1'b0;
      casc_q <= 1'b0;
      act_q  <= 1'b0;
      slv_q  <= 1'b0;
      ch_q   <= '0;
    end else if (!act_q) begin
      casc_q <= |slv_elig;
      hrq_q  <= |mst_elig;
      if (start) begin
        act_q <= 1'b1;
        slv_q <= (mst_pick == '0);
        ch_q  <= (mst_pick == '0) ? slv_pick : mst_pick;
      end
    end
  end

  assign hrq         = hrq_q;
  assign casc_req    = casc_q;
  assign grant_valid = act_q;
  assign grant_slave = slv_q;
  assign grant_ch    = ch_q;
  assign mst_dack    = !act_q ? '0 : (slv_q ? NCH'(1) : (NCH'(1) << ch_q));
  assign slv_dack    = (act_q && slv_q) ? (NCH'(1) << ch_q) : '0;

  a_r5_dack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mst_dack) && $onehot0(slv_dack));

  a_r5_grant_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> hrq);

  a_r6_cascade_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (|slv_dack) |-> (mst_dack[0] && casc_req));

  a_r8_grant_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && hlda && !tc) |=>
      (grant_valid && $stable(grant_ch) && $stable(grant_slave) && hrq));

  a_r9_tc_release: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && tc) |=>
      (!hrq && !casc_req && !grant_valid && mst_dack == '0 && slv_dack == '0));

  a_r10_hold_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !hlda) |=> (!grant_valid && !hrq));
endmodule

// File: tb/sim_cascade_dma_arbiter.sv
module sim_cascade_dma_arbiter;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:1] mst_req = '0;
  logic [NCH-1:0] mst_mask = '1;
  logic [NCH-1:0] slv_req = '0;
  logic [NCH-1:0] slv_mask = '1;
  logic hlda = 1'b0;
  logic tc = 1'b0;
  logic hrq, casc_req, grant_valid, grant_slave;
  logic [1:0] grant_ch;
  logic [NCH-1:0] mst_dack, slv_dack;

  always #5 clk = ~clk;

  cascade_dma_arbiter #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .mst_req(mst_req), .mst_mask(mst_mask),
    .slv_req(slv_req), .slv_mask(slv_mask), .hlda(hlda), .tc(tc),
    .hrq(hrq), .casc_req(casc_req), .grant_valid(grant_valid),
    .grant_slave(grant_slave), .grant_ch(grant_ch),
    .mst_dack(mst_dack), .slv_dack(slv_dack));

  int checks = 0;
  int fails = 0;
  string tag = "R1";

  bit m_hrq, m_casc, m_act, m_slv;
  int m_ch;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hrq = 0; m_casc = 0; m_act = 0; m_slv = 0; m_ch = 0;
    end else if (m_act && (tc || !hlda)) begin
      m_hrq = 0; m_casc = 0; m_act = 0; m_slv = 0; m_ch = 0;
    end else if (!m_act) begin
      int mp, sp;
      mp = -1; sp = -1;
      for (int c = NCH - 1; c >= 0; c--) begin
        if (slv_req[c] && !slv_mask[c]) sp = c;
        if (c == 0) begin
          if (m_casc && !mst_mask[0]) mp = 0;
        end else if (mst_req[c] && !mst_mask[c]) mp = c;
      end
      if (hlda && m_hrq && mp >= 0) begin
        if (mp > 0) begin m_act = 1; m_slv = 0; m_ch = mp; end
        else if (sp >= 0) begin m_act = 1; m_slv = 1; m_ch = sp; end
      end
      m_casc = (sp >= 0);
      m_hrq = (mp >= 0);
    end
  end

  task automatic check1(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int em, es;
    em = !m_act ? 0 : (m_slv ? 1 : (1 << m_ch));
    es = (m_act && m_slv) ? (1 << m_ch) : 0;
    check1("hrq", int'(hrq), int'(m_hrq));
    check1("casc_req", int'(casc_req), int'(m_casc));
    check1("grant_valid", int'(grant_valid), int'(m_act));
    if (m_act) begin
      check1("grant_slave", int'(grant_slave), int'(m_slv));
      check1("grant_ch", int'(grant_ch), m_ch);
    end
    check1("mst_dack", int'(mst_dack), em);
    check1("slv_dack", int'(slv_dack), es);
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    tick(3);
    check1("reset hrq", int'(hrq), 0);
    check1("reset dack", int'(mst_dack | slv_dack), 0);
    rst_n = 1'b1;
    tick(1);
    check1("post-reset grant", int'(grant_valid), 0);

    tag = "R2";
    mst_req[2] = 1'b1; mst_mask[2] = 1'b1;
    slv_req[1] = 1'b1; slv_mask[1] = 1'b1;
    tick(3);
    check1("masked no hrq", int'(hrq), 0);
    slv_mask[1] = 1'b0;
    tick(3);
    check1("casc up, master ch0 masked", int'(hrq), 0);

    tag = "R4";
    slv_req[1] = 1'b0; slv_mask = '1;
    mst_mask[2] = 1'b0;
    tick(1);
    check1("hrq after one clock", int'(hrq), 1);

    tag = "R5";
    mst_req[3] = 1'b1; mst_mask[3] = 1'b0;
    hlda = 1'b1;
    tick(1);
    check1("master grant ch2", int'(grant_ch), 2);
    check1("master dack", int'(mst_dack), 4);

    tag = "R8";
    mst_req[1] = 1'b1; mst_mask[1] = 1'b0; mst_req[2] = 1'b0;
    tick(3);
    check1("held grant", int'(grant_ch), 2);

    tag = "R9";
    tc = 1'b1;
    tick(1);
    tc = 1'b0;
    check1("released hrq", int'(hrq), 0);
    tick(1);
    tag = "R5";
    tick(1);
    check1("re-grant ch1", int'(grant_ch), 1);
    tag = "R10";
    hlda = 1'b0;
    tick(1);
    check1("hold drop release", int'(grant_valid), 0);
    mst_req = '0;
    tick(2);

    tag = "R3";
    mst_mask = '0;
    slv_mask = 4'b0000;
    slv_req = 4'b1100;
    tick(1);
    check1("casc one clock", int'(casc_req), 1);
    tick(1);
    tag = "R6";
    mst_req[3] = 1'b1;
    hlda = 1'b1;
    tick(1);
    check1("slave grant", int'(grant_slave), 1);
    check1("slave ch2", int'(grant_ch), 2);
    tag = "R8";
    slv_req = 4'b0001;
    slv_mask = 4'b1110;
    tick(2);
    tag = "R9";
    tc = 1'b1;
    tick(1);
    tc = 1'b0;
    check1("casc released", int'(casc_req), 0);
    tag = "R6";
    tick(3);
    tc = 1'b1;
    tick(1);
    tc = 1'b0;
    hlda = 1'b0;
    tag = "R3";
    slv_req = '0;
    mst_req = '0;
    tick(3);
    check1("casc dropped", int'(casc_req), 0);

    tag = "R7";
    slv_req = 4'b1000; slv_mask = 4'b0000;
    tick(2);
    check1("hrq from slave", int'(hrq), 1);
    slv_mask = 4'b1111;
    hlda = 1'b1;
    tick(1);
    check1("no grant stale cascade", int'(grant_valid), 0);
    tick(2);
    check1("hrq collapsed", int'(hrq), 0);
    slv_mask = 4'b0000;
    tick(3);
    check1("late slave grant", int'(grant_ch), 3);
    tc = 1'b1;
    tick(1);
    tc = 1'b0; hlda = 1'b0;
    tick(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule